// File: doc/BRIEF.md
# Bit-Test Branch and Skip Unit

This unit decides conditional control flow for a small 8-bit processor core with a 20-bit program counter. The decoder gives it one instruction at a time. Each instruction carries a class, an operand addressing form, a skip condition code, a signed 8-bit displacement, the current PC, the tested bit, and the carry and zero flags. The unit then reports whether a branch is taken and what the next PC is. For the test-and-clear form it also asks the datapath to clear the tested bit. Fetching the operand and writing the cleared bit back to memory are done elsewhere.

There are three kinds of instruction. A bit-clear branch jumps when the tested bit is 0. A set-bit branch jumps when the tested bit is 1 and then asks for that bit to be cleared. A flag skip marks the following instruction for suppression when its carry/zero condition holds. A small sequencer holds each instruction for its full cycle count. The count depends on the class, on the addressing form and on whether the branch is taken. The sequencer pulses `done` in the last cycle, and the result outputs are valid only while `done` is high. A pending skip is kept in a register and used up by the next instruction that is issued.

Top module: `bitbr_unit`

## Requirements
- R1: Class 0 (bit-clear branch) is taken exactly when `bit_val` is 0. When taken, `next_pc` = (`pc` + length + sign-extended `disp`) mod 2^20.
- R2: Class 1 (set-bit branch) is taken exactly when `bit_val` is 1. When taken, `clr_req` is high in the `done` cycle. `clr_req` is never high otherwise.
- R3: A branch that is not taken gives `next_pc` = (`pc` + length) mod 2^20, with `taken` and `clr_req` low.
- R4: Branch length is set by the `form` code. Codes 2 (accumulator bit) and 4 (register-indirect) are 3 bytes. Codes 0 (short direct), 1 (special register), 3 (flag register) and 5 (segment-prefixed indirect) are 4 bytes. Codes 6 and 7 behave as code 0.
- R5: A branch occupies 3 cycles when not taken and 5 when taken. Form 5 occupies 4 and 6 cycles instead. `done` is high in the last of these cycles, counted from the first cycle after the issue edge. `cycles` shows the count while `busy` is high.
- R6: Class 2 (skip) is 2 bytes long and takes 1 cycle, with `next_pc` = `pc` + 2. Its condition code `cond` selects the test: 0 = CY set, 1 = CY clear, 2 = Z set, 3 = Z clear, 4 = (Z or CY) clear, 5 = (Z or CY) set. Codes 6 and 7 never skip. A skip never asserts `taken`.
- R7: After a skip whose condition held, `skip_pend` is high from the cycle after its `done`. The next issued instruction is suppressed: it takes 1 cycle, `squashed` is high with `done`, `taken` and `clr_req` stay low, `next_pc` = `pc` + that instruction's own length, and `skip_pend` clears after it.
- R8: Class 3 (plain step) is 1 byte long and takes 1 cycle, with `next_pc` = `pc` + 1.
- R9: `issue` is ignored while `busy` is high. The running instruction's count, decision and `next_pc` are unchanged.
- R10: Reset clears `busy`, the cycle counter and `skip_pend`, and holds `done` low.
- R11: `next_pc`, `taken`, `clr_req` and `squashed` are all zero whenever `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue | input | 1 | Start an instruction (accepted only when idle) |
| iclass | input | 2 | 0 bit-clear branch, 1 set-bit branch, 2 skip, 3 plain step |
| form | input | 3 | Operand addressing form code for branches |
| cond | input | 3 | Skip condition code |
| disp | input | 8 | Signed branch displacement |
| pc | input | 20 | Address of the instruction |
| bit_val | input | 1 | Value of the tested bit |
| cy | input | 1 | Carry flag |
| zf | input | 1 | Zero flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| taken | output | 1 | Branch taken (valid with done) |
| clr_req | output | 1 | Request to clear the tested bit (with done) |
| squashed | output | 1 | Instruction was suppressed by a skip (with done) |
| skip_pend | output | 1 | Next instruction will be suppressed |
| cycles | output | 3 | Cycle count of the running instruction |
| next_pc | output | 20 | Next program counter (valid with done) |

## Verification
The assertions watch on every cycle that `done` only appears while `busy` is high, and that `clr_req` and `squashed` never go together with a wrong `taken`. They also check that an accepted issue starts the sequencer, that a pending skip is set only from a `done` and is cleared by a suppressed instruction, and that the counter stays in range. Only the bench scenarios can show the values themselves: target arithmetic and wrap at the 2^20 boundary, the length and cycle count for each form, the six skip conditions, and that an issue made mid-instruction has no effect.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;
  localparam int PC_W   = 20;
  localparam int DISP_W = 8;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {
    CL_BR_CLR  = 2'd0,
    CL_BR_SET  = 2'd1,
    CL_SKIP    = 2'd2,
    CL_STEP    = 2'd3
  } iclass_e;

  typedef enum logic [2:0] {
    FM_SHORT   = 3'd0,
    FM_SPECIAL = 3'd1,
    FM_ACC     = 3'd2,
    FM_FLAGREG = 3'd3,
    FM_IND     = 3'd4,
    FM_SEGIND  = 3'd5,
    FM_RSV6    = 3'd6,
    FM_RSV7    = 3'd7
  } form_e;

  typedef struct packed {
    logic             taken;
    logic             clr;
    logic             skip_hit;
    logic             squash;
    logic [PC_W-1:0]  npc;
    logic [CNT_W-1:0] cyc;
  } result_t;
endpackage

// File: rtl/bitbr_cost.sv
module bitbr_cost
  import bitbr_pkg::*;
#(
  parameter int LW = LEN_W,
  parameter int CW = CNT_W
) (
  input  iclass_e       cls,
  input  form_e         fm,
  output logic [LW-1:0] len,
  output logic [CW-1:0] cyc_nt,
  output logic [CW-1:0] cyc_t
);
  localparam logic [CW-1:0] BR_NT    = CW'(3);
  localparam logic [CW-1:0] BR_T     = CW'(5);
  localparam logic [CW-1:0] SEG_XTRA = CW'(1);

  logic [LW-1:0] br_len;
  logic          seg;

  always_comb begin
    seg = 1'b0;
    unique case (fm)
      FM_ACC, FM_IND: br_len = LW'(3);
      FM_SEGIND: begin
        br_len = LW'(4);
        seg    = 1'b1;
      end
      default: br_len = LW'(4);
    endcase
  end

  always_comb begin
    unique case (cls)
      CL_BR_CLR, CL_BR_SET: begin
        len    = br_len;
        cyc_nt = seg ? BR_NT + SEG_XTRA : BR_NT;
        cyc_t  = seg ? BR_T + SEG_XTRA : BR_T;
      end
      CL_SKIP: begin
        len    = LW'(2);
        cyc_nt = CW'(1);
        cyc_t  = CW'(1);
      end
      default: begin
        len    = LW'(1);
        cyc_nt = CW'(1);
        cyc_t  = CW'(1);
      end
    endcase
  end
endmodule

// File: rtl/bitbr_decide.sv
module bitbr_decide
  import bitbr_pkg::*;
(
  input  iclass_e    cls,
  input  logic [2:0] cond,
  input  logic       bit_val,
  input  logic       cy,
  input  logic       zf,
  output logic       taken,
  output logic       clr,
  output logic       skip_hit
);
  logic zc;
  logic cond_true;

  assign zc = zf | cy;

  always_comb begin
    unique case (cond)
      3'd0:    cond_true = cy;
      3'd1:    cond_true = ~cy;
      3'd2:    cond_true = zf;
      3'd3:    cond_true = ~zf;
      3'd4:    cond_true = ~zc;
      3'd5:    cond_true = zc;
      default: cond_true = 1'b0;
    endcase
  end

  always_comb begin
    taken    = 1'b0;
    clr      = 1'b0;
    skip_hit = 1'b0;
    unique case (cls)
      CL_BR_CLR: taken = ~bit_val;
      CL_BR_SET: begin
        taken = bit_val;
        clr   = bit_val;
      end
      CL_SKIP: skip_hit = cond_true;
      default: ;
    endcase
  end
endmodule

// File: rtl/bitbr_pcgen.sv
module bitbr_pcgen
  import bitbr_pkg::*;
#(
  parameter int AW = PC_W,
  parameter int DW = DISP_W,
  parameter int LW = LEN_W
) (
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] disp,
  input  logic          taken,
  output logic [AW-1:0] npc
);
  localparam int EXT = AW - DW;

  logic [AW-1:0] seq_pc;
  logic [AW-1:0] disp_x;

  generate
    if (EXT > 0) begin : g_ext
      assign disp_x = {{EXT{disp[DW-1]}}, disp};
    end else begin : g_trunc
      assign disp_x = disp[AW-1:0];
    end
  endgenerate

  assign seq_pc = pc + AW'(len);
  assign npc    = taken ? seq_pc + disp_x : seq_pc;
endmodule

// File: rtl/bitbr_unit.sv
module bitbr_unit
  import bitbr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [1:0]      iclass,
  input  logic [2:0]      form,
  input  logic [2:0]      cond,
  input  logic [7:0]      disp,
  input  logic [19:0]     pc,
  input  logic            bit_val,
  input  logic            cy,
  input  logic            zf,
  output logic            busy,
  output logic            done,
  output logic            taken,
  output logic            clr_req,
  output logic            squashed,
  output logic            skip_pend,
  output logic [2:0]      cycles,
  output logic [19:0]     next_pc
);
  logic rst_meta, rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  iclass_e         cls;
  form_e           fm;
  logic [LEN_W-1:0] len;
  logic [CNT_W-1:0] cyc_nt, cyc_t;
  logic            d_taken, d_clr, d_hit;
  logic            eff_taken;
  logic [PC_W-1:0] npc_calc;

  assign cls = iclass_e'(iclass);
  assign fm  = form_e'(form);

  bitbr_cost #(.LW(LEN_W), .CW(CNT_W)) u_cost (
    .cls(cls), .fm(fm), .len(len), .cyc_nt(cyc_nt), .cyc_t(cyc_t)
  );

  bitbr_decide u_dec (
    .cls(cls), .cond(cond), .bit_val(bit_val), .cy(cy), .zf(zf),
    .taken(d_taken), .clr(d_clr), .skip_hit(d_hit)
  );

  bitbr_pcgen #(.AW(PC_W), .DW(DISP_W), .LW(LEN_W)) u_pc (
    .pc(pc), .len(len), .disp(disp), .taken(eff_taken), .npc(npc_calc)
  );

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  result_t          res_q, res_d;
  logic             accept, fin;
  logic [CNT_W-1:0] cyc_sel;

  assign accept    = issue & ~busy_q;
  assign fin       = busy_q & (cnt_q == '0);
  assign eff_taken = d_taken & ~pend_q;
  assign cyc_sel   = pend_q ? CNT_W'(1) : (eff_taken ? cyc_t : cyc_nt);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    res_d  = res_q;
    pend_d = pend_q;
    if (accept) begin
      busy_d         = 1'b1;
      cnt_d          = cyc_sel - CNT_W'(1);
      res_d.taken    = eff_taken;
      res_d.clr      = d_clr & ~pend_q;
      res_d.skip_hit = d_hit & ~pend_q;
      res_d.squash   = pend_q;
      res_d.npc      = npc_calc;
      res_d.cyc      = cyc_sel;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CNT_W'(1);
    end
    if (fin) begin
      if (res_q.squash)        pend_d = 1'b0;
      else if (res_q.skip_hit) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) res_q <= res_d;
  end

  assign busy      = busy_q;
  assign done      = fin;
  assign taken     = fin & res_q.taken;
  assign clr_req   = fin & res_q.clr;
  assign squashed  = fin & res_q.squash;
  assign skip_pend = pend_q;
  assign cycles    = busy_q ? res_q.cyc : '0;
  assign next_pc   = fin ? res_q.npc : '0;

  a_r5_done_needs_busy: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> busy);
  a_r2_clr_implies_taken: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_req |-> (taken && done));
  a_r7_squash_no_branch: assert property (@(posedge clk) disable iff (!rst_sn)
    squashed |-> (!taken && !clr_req && cycles == 3'd1));
  a_r7_pend_clears: assert property (@(posedge clk) disable iff (!rst_sn)
    squashed |=> !skip_pend);
  a_r7_pend_from_done: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(skip_pend) |-> $past(done));
  a_r9_issue_starts: assert property (@(posedge clk) disable iff (!rst_sn)
    (issue && !busy) |=> busy);
  a_r9_busy_holds_count: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && !done) |=> (busy && $stable(cycles)));

  always_comb begin
    if (rst_sn) a_r5_cnt_bound: assert (cnt_q < CNT_W'(6));
  end
endmodule

// File: tb/bitbr_unit_test.sv
`timescale 1ns/1ps
module bitbr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [1:0]  iclass;
  logic [2:0]  form, cond;
  logic [7:0]  disp;
  logic [19:0] pc;
  logic        bit_val, cy, zf;
  logic        busy, done, taken, clr_req, squashed, skip_pend;
  logic [2:0]  cycles;
  logic [19:0] next_pc;

  int n_chk = 0;
  int n_bad = 0;
  int ncyc  = 0;
  bit m_pend = 0;

  always #4 clk = ~clk;

  bitbr_unit uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .iclass(iclass), .form(form),
    .cond(cond), .disp(disp), .pc(pc), .bit_val(bit_val), .cy(cy), .zf(zf),
    .busy(busy), .done(done), .taken(taken), .clr_req(clr_req),
    .squashed(squashed), .skip_pend(skip_pend), .cycles(cycles),
    .next_pc(next_pc)
  );

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int e_len(input int c, input int f);
    if (c == 2) return 2;
    if (c == 3) return 1;
    return (f == 2 || f == 4) ? 3 : 4;
  endfunction

  function automatic bit e_cond(input int cd, input bit c, input bit z);
    case (cd)
      0: return c;
      1: return !c;
      2: return z;
      3: return !z;
      4: return !(z | c);
      5: return (z | c);
      default: return 0;
    endcase
  endfunction

  function automatic bit e_taken(input int c, input bit b);
    if (c == 0) return !b;
    if (c == 1) return b;
    return 0;
  endfunction

  function automatic int e_cyc(input int c, input int f, input bit t);
    if (c >= 2) return 1;
    if (f == 5) return t ? 6 : 4;
    return t ? 5 : 3;
  endfunction

  task automatic run(input int c, input int f, input int cd, input int d,
                     input int p, input bit b, input bit fc, input bit fz,
                     input bit noisy);
    int  cnt;
    bit  sq, t, cl;
    int  len, cy_e;
    logic [19:0] np;
    sq   = m_pend;
    len  = e_len(c, f);
    t    = sq ? 0 : e_taken(c, b);
    cl   = t && (c == 1);
    cy_e = sq ? 1 : e_cyc(c, f, t);
    np   = 20'(p + len);
    if (t) np = np + {{12{d[7]}}, 8'(d)};
    @(negedge clk);
    issue = 1; iclass = 2'(c); form = 3'(f); cond = 3'(cd); disp = 8'(d);
    pc = 20'(p); bit_val = b; cy = fc; zf = fz;
    @(negedge clk);
    issue = 0;
    cnt = 1;
    if (!done) begin
      chk(next_pc == 0 && taken == 0 && clr_req == 0 && squashed == 0,
          "R11 idle outputs", next_pc, 0);
      if (noisy) begin
        issue = 1; pc = 20'(p ^ 20'h5a5a5); bit_val = !b; iclass = 2'(3 - c);
      end
    end
    while (!done && cnt < 12) begin
      @(negedge clk);
      issue = 0;
      cnt++;
    end
    chk(cnt == cy_e, noisy ? "R9 count under issue" : "R5 cycle count", cnt, cy_e);
    chk(cycles == 3'(cy_e), "R5 cycles port", cycles, cy_e);
    chk(next_pc == np, sq ? "R7 squashed pc" : (t ? "R1 target" : "R3 seq pc"),
        next_pc, np);
    chk(taken == t, c == 1 ? "R2 taken" : "R1 taken", taken, t);
    chk(clr_req == cl, "R2 clr_req", clr_req, cl);
    chk(squashed == sq, "R7 squashed", squashed, sq);
    if (sq) m_pend = 0;
    else if (c == 2 && e_cond(cd, fc, fz)) m_pend = 1;
    @(negedge clk);
    chk(skip_pend == m_pend, c == 2 ? "R6 skip cond" : "R7 pend", skip_pend, m_pend);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      ncyc++;
      if (ncyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = 32'h1d2c3b;
    void'($urandom(seed));
    issue = 0; iclass = 0; form = 0; cond = 0; disp = 0; pc = 0;
    bit_val = 0; cy = 0; zf = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !skip_pend && cycles == 0 && next_pc == 0,
        "R10 reset state", {busy, done, skip_pend}, 0);

    // R1 and R4 form lengths, R5 counts
    for (int f = 0; f < 8; f++) run(0, f, 0, 8'h10, 20'h01000, 0, 0, 0, 0);
    for (int f = 0; f < 8; f++) run(0, f, 0, 8'h10, 20'h01000, 1, 0, 0, 0);
    // R2 set-bit branch, both outcomes, segment form
    run(1, 5, 0, 8'h80, 20'h00040, 1, 0, 0, 0);
    run(1, 2, 0, 8'h80, 20'h00040, 0, 0, 0, 0);
    // R1 wrap both ways
    run(0, 0, 0, 8'h7f, 20'hfffff, 0, 0, 0, 0);
    run(0, 4, 0, 8'h80, 20'h00001, 0, 0, 0, 0);
    // R3 sequential wrap
    run(1, 1, 0, 8'h00, 20'hffffe, 0, 0, 0, 0);
    // R8 plain step
    run(3, 0, 0, 0, 20'hfffff, 0, 0, 0, 0);
    // R6 every condition and flag pair, each followed by a target for R7
    for (int cd = 0; cd < 8; cd++)
      for (int fl = 0; fl < 4; fl++) begin
        run(2, 0, cd, 0, 20'h02000, 0, fl[0], fl[1], 0);
        run(1, 3, 0, 8'h22, 20'h03000, 1, 0, 0, 0);
      end
    // R7 suppressed skip does not chain
    run(2, 0, 0, 0, 20'h100, 0, 1, 0, 0);
    run(2, 0, 0, 0, 20'h102, 0, 1, 0, 0);
    run(0, 0, 0, 8'h40, 20'h104, 0, 0, 0, 0);
    // R9 issue while busy
    run(0, 5, 0, 8'hf0, 20'h0abcd, 0, 0, 0, 1);
    run(1, 0, 0, 8'h0c, 20'h0abcd, 0, 0, 0, 1);
    // random mix
    for (int i = 0; i < 400; i++)
      run($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 7),
          $urandom_range(0, 255), $urandom_range(0, 20'hfffff),
          1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    // R10 reset clears a pending skip
    run(2, 0, 0, 0, 20'h10, 0, 1, 0, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    m_pend = 0;
    repeat (3) @(negedge clk);
    chk(!skip_pend && !busy, "R10 pend cleared", skip_pend, 0);
    run(0, 2, 0, 8'h04, 20'h20, 0, 0, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule